// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit register that, on each rising clock edge, can keep its value, move its bits one place toward the high end, move them one place toward the low end, or capture a full word from a shared parallel bus. One serial input feeds bit 0 when moving toward the high end. Another serial input feeds bit 7 when moving toward the low end. The two end bits always appear on their own outputs, so several blocks can be chained through their serial pins.

The parallel lines form one bidirectional bus. The block drives its contents onto that bus through tri-state buffers only when both active-low enables are asserted and the block is not capturing. At all other times it releases the bus to high impedance, so another agent can drive it. An active-low clear empties the register at once, whatever the clock and mode are doing.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_sel = 2'b00, a rising edge leaves all eight register bits unchanged.
- R2: With mode_sel = 2'b01, a rising edge moves every bit up one place (bit i to bit i+1) and loads ser_in_lo into bit 0.
- R3: With mode_sel = 2'b10, a rising edge moves every bit down one place (bit i to bit i-1) and loads ser_in_hi into bit 7.
- R4: With mode_sel = 2'b11, a rising edge captures the value present on par_io into the register. Bit n of the bus goes to bit n.
- R5: While rst_n is low, the register is zero. The clear takes effect at once, without waiting for a clock edge, and it overrides every mode.
- R6: end_lo always shows register bit 0 and end_hi always shows register bit 7, whatever the state of the output enables.
- R7: When out_en_a_n and out_en_b_n are both low and mode_sel is not 2'b11, par_io carries the register contents in the same cycle.
- R8: When either enable is high, or mode_sel is 2'b11, the block does not drive par_io. The bus then reads high impedance, or the external value if another agent drives it.
- R9: After rst_n is released and before the first rising edge, the register, end_lo and end_hi are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register changes on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 move up, 10 move down, 11 capture |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 when moving up |
| ser_in_hi | input | 1 | Serial bit that enters bit 7 when moving down |
| out_en_a_n | input | 1 | Bus drive enable, active low |
| out_en_b_n | input | 1 | Bus drive enable, active low |
| par_io | inout | 8 | Shared tri-state parallel bus |
| end_lo | output | 1 | Register bit 0 |
| end_hi | output | 1 | Register bit 7 |

## Verification
Whether the block drives par_io or leaves it at high impedance depends only on the present enables, mode and state. The bench therefore checks par_io 1 ns after it changes those inputs, with no clock edge in between. The register and end outputs change one rising edge after a mode is applied. The bench updates its reference at that rising edge and compares at the falling edge that follows. The clear acts without a clock edge, so its zero result is checked 1 ns after rst_n falls in the middle of a cycle.

// File: rtl/usr_pkg.sv
`timescale 1ns/1ps
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

endpackage

// File: rtl/usr_stage_mux.sv
`timescale 1ns/1ps
// Per-stage neighbour selection: builds the moved-up and moved-down words.
module usr_stage_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_bits,
    input  logic             ser_lo,
    input  logic             ser_hi,
    output logic [WIDTH-1:0] up_bits,
    output logic [WIDTH-1:0] down_bits
);
    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_low_end
            assign up_bits[i] = ser_lo;
        end else begin : g_low_mid
            assign up_bits[i] = cur_bits[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign down_bits[i] = ser_hi;
        end else begin : g_high_mid
            assign down_bits[i] = cur_bits[i+1];
        end
    end
endmodule

// File: rtl/usr_port_ctrl.sv
`timescale 1ns/1ps
// Decides when the block owns the shared parallel bus.
module usr_port_ctrl (
    input  usr_pkg::mode_e mode,
    input  logic           en_a_n,
    input  logic           en_b_n,
    output logic           drive_en
);
    import usr_pkg::*;

    logic enables_on;
    logic capturing;

    always_comb begin
        enables_on = ~en_a_n & ~en_b_n;
        capturing  = (mode == MODE_LOAD);
        drive_en   = enables_on & ~capturing;
    end
endmodule

// File: rtl/usr_core.sv
`timescale 1ns/1ps
// State register: next value computed in a struct, registered with async clear.
module usr_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  usr_pkg::mode_e   mode,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] up_bits,
    input  logic [WIDTH-1:0] down_bits,
    input  logic [WIDTH-1:0] load_bits,
    output logic [WIDTH-1:0] bits_o
);
    import usr_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } state_t;

    state_t state_d;
    state_t state_q;

    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_HOLD: state_d.bits = state_q.bits;
            MODE_UP:   state_d.bits = up_bits;
            MODE_DOWN: state_d.bits = down_bits;
            MODE_LOAD: state_d.bits = load_bits;
            default:   state_d.bits = state_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bits_o = state_q.bits;

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> (bits_o == $past(bits_o))); // R1
    AST_UP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP) |=> (bits_o[0] == $past(ser_lo)) &&
                              (bits_o[WIDTH-1:1] == $past(bits_o[WIDTH-2:0]))); // R2
    AST_DOWN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN) |=> (bits_o[WIDTH-1] == $past(ser_hi)) &&
                                (bits_o[WIDTH-2:0] == $past(bits_o[WIDTH-1:1]))); // R3
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (bits_o == $past(load_bits))); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !rst_n |-> (bits_o == '0)); // R5
endmodule

// File: rtl/usr_shift_reg.sv
`timescale 1ns/1ps
// Universal shift register with a shared tri-state parallel bus.
module usr_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             out_en_a_n,
    input  logic             out_en_b_n,
    inout  wire  [WIDTH-1:0] par_io,
    output logic             end_lo,
    output logic             end_hi
);
    import usr_pkg::*;

    localparam int TOP = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] cur_bits;
    logic [WIDTH-1:0] up_bits;
    logic [WIDTH-1:0] down_bits;
    logic [WIDTH-1:0] bus_in;
    logic             drive_en;

    assign mode   = mode_e'(mode_sel);
    assign bus_in = par_io;

    usr_stage_mux #(.WIDTH(WIDTH)) i_stage_mux (
        .cur_bits  (cur_bits),
        .ser_lo    (ser_in_lo),
        .ser_hi    (ser_in_hi),
        .up_bits   (up_bits),
        .down_bits (down_bits)
    );

    usr_core #(.WIDTH(WIDTH)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ser_lo    (ser_in_lo),
        .ser_hi    (ser_in_hi),
        .up_bits   (up_bits),
        .down_bits (down_bits),
        .load_bits (bus_in),
        .bits_o    (cur_bits)
    );

    usr_port_ctrl i_port_ctrl (
        .mode     (mode),
        .en_a_n   (out_en_a_n),
        .en_b_n   (out_en_b_n),
        .drive_en (drive_en)
    );

    assign par_io = drive_en ? cur_bits : {WIDTH{1'bz}};
    assign end_lo = cur_bits[0];
    assign end_hi = cur_bits[TOP];

    AST_RELEASE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_a_n || out_en_b_n) |-> !drive_en); // R8
    AST_RELEASE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> !drive_en); // R8
    AST_DRIVE_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en_a_n && !out_en_b_n && mode_sel != 2'b11) |-> drive_en); // R7
endmodule

// File: tb/test_usr_shift_reg.sv
`timescale 1ns/1ps
module test_usr_shift_reg;
    localparam real PERIOD = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       ser_in_lo = 1'b0;
    logic       ser_in_hi = 1'b0;
    logic       out_en_a_n = 1'b1;
    logic       out_en_b_n = 1'b1;
    logic       ext_drv = 1'b0;
    logic [7:0] ext_val = 8'h00;
    wire  [7:0] par_io;
    logic       end_lo;
    logic       end_hi;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] model = 8'h00;

    assign par_io = ext_drv ? ext_val : 8'bz;

    always #(PERIOD/2) clk = ~clk;

    usr_shift_reg i_usr_shift_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .ser_in_lo  (ser_in_lo),
        .ser_in_hi  (ser_in_hi),
        .out_en_a_n (out_en_a_n),
        .out_en_b_n (out_en_b_n),
        .par_io     (par_io),
        .end_lo     (end_lo),
        .end_hi     (end_hi)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Checks the bus against ownership rules for the current inputs.
    task automatic chk_bus();
        logic owns;
        owns = !out_en_a_n && !out_en_b_n && mode_sel != 2'b11;
        if (owns)
            chk("R7", "bus driven", par_io, model);
        else if (ext_drv)
            chk("R8", "bus external", par_io, ext_val);
        else
            chk("R8", "bus released", par_io, 8'bz);
    endtask

    task automatic chk_ends(input string req);
        chk(req, "end_lo", {7'b0, end_lo}, {7'b0, model[0]});
        chk(req, "end_hi", {7'b0, end_hi}, {7'b0, model[7]});
    endtask

    // One clocked operation, begun just after a falling edge.
    task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                        input logic ea, input logic eb,
                        input logic edrv, input logic [7:0] ev);
        mode_sel = m; ser_in_lo = sl; ser_in_hi = sh;
        out_en_a_n = ea; out_en_b_n = eb;
        ext_drv = (m == 2'b11) ? 1'b1 : (edrv && !(!ea && !eb));
        ext_val = ev;
        #1;
        chk_bus();
        chk_ends("R6");
        @(posedge clk);
        if (rst_n) begin
            case (m)
                2'b01:   model = {model[6:0], sl};
                2'b10:   model = {sh, model[7:1]};
                2'b11:   model = ev;
                default: model = model;
            endcase
        end
        @(negedge clk);
        chk_ends(tag_of(m));
    endtask

    // Reads the full register through the bus without clocking.
    task automatic readback(input string req);
        mode_sel = 2'b00; out_en_a_n = 1'b0; out_en_b_n = 1'b0; ext_drv = 1'b0;
        #1;
        chk(req, "readback", par_io, model);
        @(negedge clk);
    endtask

    // Clear asserted in the middle of a cycle, held over an edge, released.
    task automatic mid_clear();
        #2;
        rst_n = 1'b0;
        model = 8'h00;
        mode_sel = 2'b11; ext_drv = 1'b1; ext_val = 8'hA5;
        #1;
        chk_ends("R5");
        @(posedge clk);
        @(negedge clk);
        chk_ends("R5");
        mode_sel = 2'b00; out_en_a_n = 1'b0; out_en_b_n = 1'b0; ext_drv = 1'b0;
        #1;
        chk("R5", "bus during clear", par_io, 8'h00);
        rst_n = 1'b1;
        #1;
        chk("R9", "bus after release", par_io, 8'h00);
        chk_ends("R9");
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state.
        out_en_a_n = 1'b0; out_en_b_n = 1'b0;
        #1;
        chk("R5", "bus in reset", par_io, 8'h00);
        chk_ends("R5");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "bus after release", par_io, 8'h00);
        chk_ends("R9");
        @(negedge clk);

        // Capture, then hold.
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3);
        readback("R4");
        step(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        step(2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
        readback("R1");

        // Move up with alternating serial bits.
        for (int k = 0; k < 4; k++) begin
            step(2'b01, k[0], 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
            readback("R2");
        end

        // Move down with ones.
        for (int k = 0; k < 5; k++) begin
            step(2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
            readback("R3");
        end

        // Enables high: ends still valid, bus released or external.
        step(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
        step(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C);
        step(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        readback("R6");

        // Capture while enables would otherwise drive.
        step(2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A);
        readback("R4");
        step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
        readback("R4");

        mid_clear();

        // Random operation with periodic mid-cycle clears.
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(3, 0), 1'($urandom), 1'($urandom),
                 1'($urandom_range(3, 0) == 0), 1'($urandom_range(3, 0) == 0),
                 1'($urandom), 8'($urandom));
            if (n % 16 == 15) readback("R7");
            if (n % 500 == 250) mid_clear();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule